// File: doc/BRIEF.md
# Negacyclic Schoolbook Polynomial Multiplier

This block multiplies two polynomials in the ring of integers modulo 2^13 reduced by x^N+1 (N = 256 by default). One operand is a "secret" polynomial with small signed coefficients. It is loaded all at once into a shift register. The other operand is a "public" polynomial with 13-bit coefficients. Its coefficients stream in one per accepted beat, lowest degree first. Each accepted beat goes through the same steps:

- A single shared unit forms the multiples 0x to 5x of the incoming coefficient, using shifts and adds only.
- Every one of the N lanes selects the multiple that matches its current secret coefficient.
- Each lane adds or subtracts that multiple into its own 13-bit accumulator.
- The secret register then rotates up by one place. The coefficient that wraps from the top to position 0 has its sign inverted, which applies the x^N = -1 reduction.

A controller typically loads the secret, pulses `start`, and streams N public coefficients. It then reads the N accumulators in parallel once `done` pulses. Accumulators are only zeroed by `clear`. Because of this, an inner product of polynomial arrays is formed by reloading the secret and running further products without clearing in between.

The coefficient input is valid/ready. `coef_ready` is low while the block is idle. It is high from the cycle after an accepted `start` until the N-th beat is accepted. While a product runs the block never applies back-pressure: the source may hold `coef_valid` low for any number of cycles, and the product simply waits. Beats offered while `coef_ready` is low are not consumed.

Top module: `ring_schoolbook_mul`

## Requirements
- R1: After reset every accumulator is zero, `coef_ready` is low and `done` is low.
- R2: After `clear`, a loaded secret s and N accepted public coefficients a_0..a_{N-1} leave accumulator j equal to the sum over i of a_i*s_{j-i} (for i<=j) minus a_i*s_{N+j-i} (for i>j), modulo 2^13.
- R3: A `clear` high at a clock edge makes every accumulator zero after that edge.
- R4: Without `clear`, a further product adds onto the accumulator contents left by the previous one.
- R5: A secret coefficient is 4 bits: bit 3 is the sign (1 = negative) and bits 2:0 are the magnitude. Magnitude 0 contributes nothing whatever the sign, and magnitudes 6 and 7 also contribute nothing.
- R6: `coef_ready` rises in the cycle after `start` is seen while idle. It stays high until exactly N beats (`coef_valid` and `coef_ready` both high) have been accepted, then falls. Coefficients offered while it is low change no accumulator.
- R7: `done` is high for exactly one cycle: the cycle after the edge that accepted the N-th beat.
- R8: A cycle with `coef_ready` high and `coef_valid` low changes no accumulator and does not advance the product.
- R9: `start` and `sec_load` are ignored while a product is running; the result equals the product of the secret loaded before `start`.
- R10: Accumulation wraps modulo 2^13, including at the extreme values -4096 times -5 on every lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Zero all accumulators at the next edge |
| start | input | 1 | Begin a product of N beats (honoured only when idle) |
| sec_load | input | 1 | Capture `sec_in` into the secret register (honoured only when idle) |
| sec_in | input | N*4 | Secret polynomial, coefficient j in bits 4j+3:4j |
| coef_valid | input | 1 | Public coefficient present on `coef_data` |
| coef_ready | output | 1 | Block accepts a public coefficient this cycle |
| coef_data | input | 13 | Public coefficient, two's complement |
| done | output | 1 | One-cycle pulse after the last beat of a product |
| acc_out | output | N*13 | Accumulators, entry j in bits 13j+12:13j |

## Verification
Several handshake rules are checked on every cycle:

- `done` lasts a single cycle and coincides with exactly N beats counted since the accepted start.
- `coef_ready` cannot drop without an accepted beat.
- A stall cycle leaves the accumulators untouched.
- `clear` empties them.

The arithmetic needs the bench's scenarios: the negacyclic product, the sign-magnitude corner codes, modular wrap, accumulation across products, and immunity to `start`/`sec_load` during a run. These are checked on a small ring against sums computed directly from the definition.

// File: rtl/pmul_pkg.sv
package pmul_pkg;
  localparam int CW      = 13;          // coefficient / accumulator width
  localparam int SW      = 4;           // secret coefficient width
  localparam int MAG_W   = SW - 1;      // magnitude field width
  localparam int MAG_MAX = 5;           // largest supported magnitude
  localparam int NMULT   = MAG_MAX + 1; // number of shared multiples

  typedef logic [CW-1:0]            coef_t;
  typedef logic [SW-1:0]            sec_t;
  typedef logic [NMULT-1:0][CW-1:0] mults_t;
endpackage

// File: rtl/pmul_multiples.sv
module pmul_multiples
  import pmul_pkg::*;
(
  input  coef_t  a,
  output mults_t m
);
  // k*a built from shifted copies of a for each set bit of k
  always_comb begin
    for (int k = 0; k < NMULT; k++) begin
      m[k] = '0;
      for (int b = 0; b < MAG_W; b++) begin
        if (((k >> b) & 1) == 1) m[k] = m[k] + coef_t'(a << b);
      end
    end
  end
endmodule

// File: rtl/pmul_lane.sv
module pmul_lane
  import pmul_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clr,
  input  logic   en,
  input  mults_t mults,
  input  sec_t   s,
  output coef_t  acc
);
  logic [MAG_W-1:0] mag;
  logic             neg;
  coef_t            pick;
  coef_t            nxt;

  assign mag = s[MAG_W-1:0];
  assign neg = s[SW-1];

  // out-of-range magnitudes select nothing
  always_comb begin
    pick = '0;
    for (int k = 0; k < NMULT; k++) begin
      if (int'(mag) == k) pick = mults[k];
    end
  end

  assign nxt = neg ? (acc - pick) : (acc + pick);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    acc <= '0;
    else if (clr)  acc <= '0;
    else if (en)   acc <= nxt;
  end
endmodule

// File: rtl/pmul_secret_reg.sv
module pmul_secret_reg
  import pmul_pkg::*;
#(
  parameter int N = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          rot,
  input  logic [N*SW-1:0] load_vec,
  output logic [N*SW-1:0] sec_vec
);
  sec_t r [N];

  for (genvar j = 0; j < N; j++) begin : g_pos
    if (j == 0) begin : g_wrap
      // wrapped coefficient picks up a sign flip (x^N = -1)
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    r[j] <= '0;
        else if (load) r[j] <= load_vec[j*SW +: SW];
        else if (rot)  r[j] <= {~r[N-1][SW-1], r[N-1][MAG_W-1:0]};
      end
    end else begin : g_shift
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    r[j] <= '0;
        else if (load) r[j] <= load_vec[j*SW +: SW];
        else if (rot)  r[j] <= r[j-1];
      end
    end
    assign sec_vec[j*SW +: SW] = r[j];
  end
endmodule

// File: rtl/pmul_ctrl.sv
module pmul_ctrl #(
  parameter int N = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic in_valid,
  output logic in_ready,
  output logic beat,
  output logic done
);
  localparam int CNT_W = (N > 1) ? $clog2(N) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(N - 1);

  logic [CNT_W-1:0] cnt;
  logic             busy_q;
  logic             done_q;
  logic             last;

  assign beat     = busy_q && in_valid;
  assign last     = (cnt == LAST);
  assign in_ready = busy_q;
  assign done     = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt    <= '0;
    end else begin
      done_q <= beat && last;
      if (!busy_q) begin
        if (start) begin
          busy_q <= 1'b1;
          cnt    <= '0;
        end
      end else if (beat) begin
        if (last) busy_q <= 1'b0;
        else      cnt    <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ring_schoolbook_mul.sv
module ring_schoolbook_mul
  import pmul_pkg::*;
#(
  parameter int N = 256
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            start,
  input  logic            sec_load,
  input  logic [N*SW-1:0] sec_in,
  input  logic            coef_valid,
  output logic            coef_ready,
  input  logic [CW-1:0]   coef_data,
  output logic            done,
  output logic [N*CW-1:0] acc_out
);
  logic   beat;
  logic   load_ok;
  mults_t mults;
  logic [N*SW-1:0] sec_vec;

  pmul_ctrl #(.N(N)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .in_valid (coef_valid),
    .in_ready (coef_ready),
    .beat     (beat),
    .done     (done)
  );

  // secret may only change between products
  assign load_ok = sec_load && !coef_ready;

  pmul_secret_reg #(.N(N)) u_sec (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_ok),
    .rot      (beat),
    .load_vec (sec_in),
    .sec_vec  (sec_vec)
  );

  pmul_multiples u_mult (
    .a (coef_data),
    .m (mults)
  );

  for (genvar j = 0; j < N; j++) begin : g_lane
    pmul_lane u_lane (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clear),
      .en    (beat),
      .mults (mults),
      .s     (sec_vec[j*SW +: SW]),
      .acc   (acc_out[j*CW +: CW])
    );
  end
endmodule

// File: rtl/pmul_chk.sv
module pmul_chk
  import pmul_pkg::*;
#(
  parameter int N = 256
) (
  input logic            clk,
  input logic            rst_n,
  input logic            clear,
  input logic            start,
  input logic            coef_valid,
  input logic            coef_ready,
  input logic            done,
  input logic [N*CW-1:0] acc_out
);
  localparam int BW = $clog2(N + 1);
  logic [BW-1:0] beats;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        beats <= '0;
    else if (start && !coef_ready)     beats <= '0;
    else if (coef_valid && coef_ready) beats <= beats + 1'b1;
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (beats == BW'(N)));

  // R6
  idle_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !coef_ready);

  // R6
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (coef_ready && !coef_valid) |=> coef_ready);

  // R3
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (acc_out == '0));

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (coef_ready && !coef_valid && !clear) |=> $stable(acc_out));
endmodule

bind ring_schoolbook_mul pmul_chk #(.N(N)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clear      (clear),
  .start      (start),
  .coef_valid (coef_valid),
  .coef_ready (coef_ready),
  .done       (done),
  .acc_out    (acc_out)
);

// File: tb/tb_ring_schoolbook_mul.sv
module tb_ring_schoolbook_mul;
  localparam int NT = 8;
  localparam int CWT = 13;
  localparam int SWT = 4;

  logic clk = 0;
  logic rst_n = 0;
  logic clear = 0, start = 0, sec_load = 0, coef_valid = 0;
  logic [NT*SWT-1:0] sec_in = '0;
  logic [CWT-1:0] coef_data = '0;
  logic coef_ready, done;
  logic [NT*CWT-1:0] acc_out;

  int checks = 0, errors = 0;
  int pub [NT];
  logic [3:0] sec [NT];
  int expv [NT];
  bit finished = 0;

  always #5 clk = ~clk;

  ring_schoolbook_mul #(.N(NT)) dut (
    .clk(clk), .rst_n(rst_n), .clear(clear), .start(start),
    .sec_load(sec_load), .sec_in(sec_in), .coef_valid(coef_valid),
    .coef_ready(coef_ready), .coef_data(coef_data), .done(done),
    .acc_out(acc_out)
  );

  function automatic int sval(logic [3:0] c);
    int m;
    m = (c[2:0] > 3'd5) ? 0 : int'(c[2:0]);
    return c[3] ? -m : m;
  endfunction

  function automatic int wrap13(int x);
    return ((x % 8192) + 8192) % 8192;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  // expected accumulators after one more product (add=0 starts from zero)
  task automatic model(bit add);
    for (int j = 0; j < NT; j++) begin
      int t;
      t = add ? expv[j] : 0;
      for (int i = 0; i < NT; i++) begin
        if (i <= j) t += pub[i] * sval(sec[j-i]);
        else        t -= pub[i] * sval(sec[NT+j-i]);
      end
      expv[j] = wrap13(t);
    end
  endtask

  task automatic check_acc(string req);
    int bad;
    bad = -1;
    for (int j = 0; j < NT; j++)
      if (int'(acc_out[j*CWT +: CWT]) != expv[j] && bad < 0) bad = j;
    if (bad < 0) chk(1'b1, req, 0, 0);
    else chk(1'b0, req, int'(acc_out[bad*CWT +: CWT]), expv[bad]);
  endtask

  task automatic load_secret();
    for (int j = 0; j < NT; j++) sec_in[j*SWT +: SWT] = sec[j];
    @(negedge clk); sec_load = 1;
    @(negedge clk); sec_load = 0;
  endtask

  task automatic do_clear();
    @(negedge clk); clear = 1;
    @(negedge clk); clear = 0;
  endtask

  // gaps: random stalls (R8); disturb: start/sec_load mid-run (R9)
  task automatic run_product(bit gaps, bit disturb);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    for (int k = 0; k < NT; k++) begin
      if (gaps) begin
        while ($urandom_range(0, 2) == 0) begin
          coef_valid = 0;
          @(negedge clk);
        end
      end
      if (disturb && k == NT/2) begin
        start = 1; sec_load = 1; sec_in = ~sec_in;
      end else begin
        start = 0; sec_load = 0;
      end
      coef_valid = 1;
      coef_data = pub[k][CWT-1:0];
      if (!coef_ready) chk(1'b0, "R6 ready during run", 0, 1);
      @(negedge clk);
    end
    coef_valid = 0; start = 0; sec_load = 0;
    chk(done == 1'b1, "R7 done after last beat", done, 1);
    @(negedge clk);
    chk(done == 1'b0, "R7 done single cycle", done, 0);
    chk(coef_ready == 1'b0, "R6 ready low after N beats", coef_ready, 0);
  endtask

  task automatic rand_pub();
    for (int i = 0; i < NT; i++) pub[i] = $urandom_range(0, 8191) - 4096;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(acc_out == '0, "R1 accumulators zero", 0, 0);
    chk(coef_ready == 1'b0, "R1 ready low", coef_ready, 0);
    chk(done == 1'b0, "R1 done low", done, 0);
    rst_n = 1;
    @(negedge clk);
    chk(coef_ready == 1'b0, "R1 idle after reset", coef_ready, 0);

    // R2 basic product
    for (int j = 0; j < NT; j++) sec[j] = 4'(j % 6);
    for (int i = 0; i < NT; i++) pub[i] = i + 1;
    load_secret(); do_clear(); model(0);
    run_product(0, 0);
    check_acc("R2 basic product");

    // R6 beats offered while idle are ignored
    coef_valid = 1; coef_data = 13'd77;
    repeat (3) @(negedge clk);
    coef_valid = 0;
    check_acc("R6 idle beats ignored");

    // R5/R2 sweep: every code at every position
    for (int code = 0; code < 16; code++) begin
      for (int p = 0; p < NT; p++) begin
        for (int j = 0; j < NT; j++) sec[j] = 4'd0;
        sec[p] = 4'(code);
        rand_pub();
        load_secret(); do_clear(); model(0);
        run_product(0, 0);
        check_acc((code == 8 || code[2:0] > 5) ? "R5 null code" : "R2 single term");
      end
    end

    // R8 random secrets with stalls
    for (int t = 0; t < 20; t++) begin
      for (int j = 0; j < NT; j++) sec[j] = 4'($urandom_range(0, 15));
      rand_pub();
      load_secret(); do_clear(); model(0);
      run_product(1, 0);
      check_acc("R8 product with stalls");
    end

    // R10 extreme wrap
    for (int j = 0; j < NT; j++) sec[j] = 4'b1101;
    for (int i = 0; i < NT; i++) pub[i] = -4096;
    load_secret(); do_clear(); model(0);
    run_product(0, 0);
    check_acc("R10 wrap extremes");
    for (int j = 0; j < NT; j++) sec[j] = 4'b0101;
    for (int i = 0; i < NT; i++) pub[i] = 4095;
    load_secret(); do_clear(); model(0);
    run_product(0, 0);
    check_acc("R10 wrap positive extremes");

    // R4 accumulation across products
    for (int t = 0; t < 3; t++) begin
      for (int j = 0; j < NT; j++) sec[j] = 4'($urandom_range(0, 15));
      rand_pub();
      load_secret();
      if (t == 0) begin do_clear(); model(0); end
      else model(1);
      run_product(0, 0);
      check_acc("R4 accumulated inner product");
    end

    // R3 clear
    do_clear();
    chk(acc_out == '0, "R3 clear zeroes", 0, 0);

    // R9 start/sec_load ignored while running
    for (int t = 0; t < 4; t++) begin
      for (int j = 0; j < NT; j++) sec[j] = 4'($urandom_range(0, 15));
      rand_pub();
      load_secret(); do_clear(); model(0);
      run_product(t[0], 1);
      check_acc("R9 disturbance ignored");
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule